// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Generator

This block is the two-wire serial slave that holds the six 8-bit configuration bytes of an on-chip clock generator. A host on the board writes the bytes over the bus and reads them back. The block drives the current contents onto a flat parallel bus. The rest of the clock generator uses that bus for output enables, spread control and frequency selection.

The framing is fixed, and there is no register pointer. A write carries an address byte, then a command byte, then a length byte. The block acknowledges the command and length bytes and then throws them away. Every byte after them lands in register 0, 1, 2 and so on upward. A read first returns a length byte, then the registers from 0 upward. The block never stretches the clock. It samples SCL and SDA through two-flop synchronizers followed by a short glitch filter. It pulls SDA low through an open-drain output enable.

Top module: `clk_cfg_i2c`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69, is acknowledged. Any other address byte is not acknowledged, and the block ignores the bus until the next start.
- R2: In a write, the two bytes after the address (command, then length) are both acknowledged and leave every register unchanged.
- R3: In a write, each later byte is acknowledged and stored. Bytes are received MSB first and go to register 0, then 1, up to 5. Register k appears on `cfgBytes[8k+7:8k]`.
- R4: A stop after any complete byte keeps all fully received bytes. A partly received byte and all registers above it keep their previous values.
- R5: A read returns the value 6, then registers 0 to 5 in order, MSB first. Every byte the master asks for after register 5 reads 0xFF.
- R6: After reset, register 0 is 0x1E, registers 1 and 2 are 0xFF, registers 3 to 5 are 0x00, and SDA is released.
- R7: The SDA output enable changes only while SCL is low.
- R8: In a write, bytes beyond register 5 are acknowledged and discarded.
- R9: When the master does not acknowledge a read byte, transmission ends. SDA stays released until the next start, and it is also released after any stop.
- R10: A repeated start returns the block to the address phase. It releases SDA, and the next write again begins at register 0.
- R11: A pulse on SCL or SDA lasting one clock cycle is filtered out and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset; loads the default register values |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| cfgBytes | output | 48 | Register contents; register k in bits 8k+7:8k |

## Verification
Each bus pin reaches the control logic about six system clocks after it changes: two synchronizer stages, three filter stages and one edge-detect register. The acknowledge or data bit that answers an SCL falling edge therefore reaches SDA about seven clocks after that edge. The bench holds SCL low for two quarter periods of sixteen clocks each and samples SDA a full quarter after SCL rises, so every bit has settled long before it is compared. Register values are compared after the stop sequence has fully finished, at least a quarter period after the last byte could have been committed. The output-enable timing rule is checked by watching SDA drive while SCL has been high for more than eight clocks.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int NUM_REGS = 6;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } busState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       shiftIn;
    logic       loadTx;
    logic       shiftTx;
    logic       commit;
    logic [2:0] txSel;
    logic [2:0] wrIdx;
  } dpCtl_t;

  localparam logic [2:0] SEL_COUNT = 3'd6;
  localparam logic [2:0] SEL_FILL  = 3'd7;
endpackage

// File: rtl/clk_cfg_deglitch.sv
module clk_cfg_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);
  logic [1:0]          syncQ;
  logic [FILT_LEN-1:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      hist   <= '1;
      pinOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], pinIn};
      hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
      if (&hist)
        pinOut <= 1'b1;
      else if (~|hist)
        pinOut <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpCtl_t     ctl,
  output logic       sdaOe
);
  localparam logic [3:0] DATA_SLOT = 4'd3;
  localparam logic [3:0] READ_SLOT = 4'd2;
  localparam logic [3:0] REG_CNT   = 4'(NUM_REGS);

  busState_e  state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic [3:0] slot, slotN, nextSlot;
  logic       isRead, isReadN;
  logic       ackSeen, ackSeenN;
  logic       sclP, sdaP;

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclF & ~sclP;
  assign sclFall   = ~sclF & sclP;
  assign startSeen = sclF & sclP & sdaP & ~sdaF;
  assign stopSeen  = sclF & sclP & ~sdaP & sdaF;
  assign nextSlot  = (slot == 4'hF) ? slot : slot + 4'd1;

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    slotN    = slot;
    isReadN  = isRead;
    ackSeenN = ackSeen;
    ctl      = '0;
    if (startSeen) begin
      stateN  = ST_RX;
      bitCntN = '0;
      slotN   = '0;
    end else if (stopSeen) begin
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (slot == 4'd0) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateN  = ST_RX_ACK;
                isReadN = rxByte[0];
              end else begin
                stateN = ST_IDLE;
              end
            end else begin
              stateN = ST_RX_ACK;
              if (slot >= DATA_SLOT && slot < DATA_SLOT + REG_CNT) begin
                ctl.commit = 1'b1;
                ctl.wrIdx  = 3'(slot - DATA_SLOT);
              end
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            slotN   = nextSlot;
            bitCntN = '0;
            if (isRead) begin
              stateN    = ST_TX;
              ctl.loadTx = 1'b1;
              ctl.txSel = SEL_COUNT;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = ST_TX_ACK;
            end else begin
              ctl.shiftTx = 1'b1;
              bitCntN     = bitCnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            ackSeenN = ~sdaF;
          end else if (sclFall) begin
            if (ackSeen) begin
              stateN     = ST_TX;
              bitCntN    = '0;
              slotN      = nextSlot;
              ctl.loadTx = 1'b1;
              if (nextSlot >= READ_SLOT && nextSlot < READ_SLOT + REG_CNT)
                ctl.txSel = 3'(nextSlot - READ_SLOT);
              else
                ctl.txSel = SEL_FILL;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      slot    <= '0;
      isRead  <= 1'b0;
      ackSeen <= 1'b0;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      slot    <= slotN;
      isRead  <= isReadN;
      ackSeen <= ackSeenN;
      sclP    <= sclF;
      sdaP    <= sdaF;
    end
  end

  assign sdaOe = (state == ST_RX_ACK) | ((state == ST_TX) & ~txBit);
endmodule

// File: rtl/clk_cfg_dp.sv
module clk_cfg_dp
  import clk_cfg_pkg::*;
#(
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = 48'h0000_00FF_FF1E
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaF,
  input  dpCtl_t                     ctl,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txBit,
  output logic [NUM_REGS*BYTE_W-1:0] cfgBytes
);
  logic [BYTE_W-1:0] regArr [NUM_REGS];
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rxByte <= '0;
    else if (ctl.shiftIn)
      rxByte <= {rxByte[BYTE_W-2:0], sdaF};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regArr[g] <= REG_DEFAULTS[g*BYTE_W +: BYTE_W];
      else if (ctl.commit && ctl.wrIdx == 3'(g))
        regArr[g] <= rxByte;
    end
    assign cfgBytes[g*BYTE_W +: BYTE_W] = regArr[g];
  end

  always_comb begin
    loadVal = '1;
    if (ctl.txSel == SEL_COUNT)
      loadVal = BYTE_W'(NUM_REGS);
    else
      for (int k = 0; k < NUM_REGS; k++)
        if (ctl.txSel == 3'(k)) loadVal = regArr[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txShift <= '1;
    else if (ctl.loadTx)
      txShift <= loadVal;
    else if (ctl.shiftTx)
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

  assign txBit = txShift[BYTE_W-1];
endmodule

// File: rtl/clk_cfg_i2c.sv
module clk_cfg_i2c
  import clk_cfg_pkg::*;
#(
  parameter logic [6:0]                 DEV_ADDR     = 7'h69,
  parameter int                         FILT_LEN     = 3,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = 48'h0000_00FF_FF1E
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] cfgBytes
);
  logic        sclF, sdaF, txBit;
  logic [7:0]  rxByte;
  dpCtl_t      ctl;

  clk_cfg_deglitch #(.FILT_LEN(FILT_LEN)) u_sclFilt (
    .clk(clk), .rstN(rstN), .pinIn(sclIn), .pinOut(sclF));
  clk_cfg_deglitch #(.FILT_LEN(FILT_LEN)) u_sdaFilt (
    .clk(clk), .rstN(rstN), .pinIn(sdaIn), .pinOut(sdaF));

  clk_cfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF),
    .rxByte(rxByte), .txBit(txBit), .ctl(ctl), .sdaOe(sdaOe));

  clk_cfg_dp #(.REG_DEFAULTS(REG_DEFAULTS)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(sdaF), .ctl(ctl),
    .rxByte(rxByte), .txBit(txBit), .cfgBytes(cfgBytes));
endmodule

// File: rtl/clk_cfg_chk.sv
module clk_cfg_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rstN,
  input logic         sclF,
  input logic         sdaF,
  input logic         sdaOe,
  input logic [W-1:0] cfgBytes
);
  assert_oe_moves_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclF);

  assert_cfg_moves_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgBytes) |-> !sclF);

  assert_release_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF) && sdaF && !$past(sdaF)) |=> !sdaOe);

  assert_release_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && $past(sclF) && !sdaF && $past(sdaF)) |=> !sdaOe);
endmodule

bind clk_cfg_i2c clk_cfg_chk #(.W(clk_cfg_pkg::NUM_REGS*clk_cfg_pkg::BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF),
  .sdaOe(sdaOe), .cfgBytes(cfgBytes));

// File: tb/test_clk_cfg_i2c.sv
module test_clk_cfg_i2c;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic [47:0] cfg;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  clk_cfg_i2c i_clk_cfg_i2c (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .cfgBytes(cfg));

  int applied = 0;
  int misses = 0;
  logic [47:0] expQ[$];
  string reqQ[$];
  logic [7:0] model [6];
  int r7Bad = 0;
  int hiCnt = 0;
  logic prevOe = 1'b0;

  function automatic logic [47:0] modelVec();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic expectItem(string r, logic [47:0] v);
    expQ.push_back(v);
    reqQ.push_back(r);
  endtask

  task automatic observe(logic [47:0] act);
    logic [47:0] e;
    string r;
    applied++;
    if (expQ.size() == 0) begin
      misses++;
      $display("FAIL scoreboard empty actual %h expected none", act);
      return;
    end
    e = expQ.pop_front();
    r = reqQ.pop_front();
    if (act !== e) begin
      misses++;
      $display("FAIL %s actual %h expected %h", r, act, e);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitOut(logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // bit with a one-cycle SCL pulse while low and a one-cycle SDA dip while high
  task automatic bitOutGlitch(logic b);
    sdaM = b;
    repeat (4) @(negedge clk);
    sclM = 1'b1; @(negedge clk); sclM = 1'b0;
    repeat (Q - 5) @(negedge clk);
    sclM = 1'b1;
    repeat (Q) @(negedge clk);
    if (b) begin sdaM = 1'b0; @(negedge clk); sdaM = 1'b1; end
    else   begin @(negedge clk); end
    repeat (Q - 1) @(negedge clk);
    sclM = 1'b0; waitQ();
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic startC();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, bit glitch, output logic ackd);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (glitch) bitOutGlitch(v[i]);
      else bitOut(v[i]);
    end
    bitIn(a);
    ackd = ~a;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bitIn(b);
      v[i] = b;
    end
    bitOut(~ack);
  endtask

  // write: address, command, length, then data bytes; acks are scored
  task automatic writeSeq(logic [7:0] d[], string r, bit glitch);
    logic a;
    sendByte(8'hD2, 1'b0, a); expectItem("R1", 48'd1); observe({47'd0, a});
    sendByte(8'h5A, 1'b0, a); expectItem("R2", 48'd1); observe({47'd0, a});
    sendByte(8'h06, 1'b0, a); expectItem("R2", 48'd1); observe({47'd0, a});
    foreach (d[i]) begin
      sendByte(d[i], glitch, a);
      expectItem(r, 48'd1); observe({47'd0, a});
      if (i < 6) model[i] = d[i];
    end
  endtask

  always @(negedge clk) begin
    if (sclM) hiCnt++;
    else hiCnt = 0;
    if (rstN && hiCnt > 8 && sdaOe !== prevOe) r7Bad++;
    prevOe = sdaOe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    model[0] = 8'h1E; model[1] = 8'hFF; model[2] = 8'hFF;
    model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    expectItem("R6", modelVec()); observe(cfg);
    expectItem("R6", 48'd0); observe({47'd0, sdaOe});

    // R3 full write
    startC();
    writeSeq('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, "R3", 1'b0);
    stopC();
    expectItem("R3", 48'h6655_4433_2211); observe(cfg);

    // R2 command and length only
    startC();
    writeSeq('{}, "R2", 1'b0);
    stopC();
    expectItem("R2", modelVec()); observe(cfg);

    // R4 two whole bytes, then three bits of a third
    startC();
    writeSeq('{8'hA1, 8'hB2}, "R4", 1'b0);
    bitOut(1'b1); bitOut(1'b1); bitOut(1'b0);
    stopC();
    expectItem("R4", modelVec()); observe(cfg);

    // R8 eight data bytes, last two dropped
    startC();
    writeSeq('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08}, "R8", 1'b0);
    stopC();
    expectItem("R8", 48'h0605_0403_0201); observe(cfg);

    // R1 foreign address is not acknowledged and later bytes are ignored
    startC();
    sendByte(8'hA0, 1'b0, a); expectItem("R1", 48'd0); observe({47'd0, a});
    sendByte(8'h00, 1'b0, a); expectItem("R1", 48'd0); observe({47'd0, a});
    stopC();
    expectItem("R1", modelVec()); observe(cfg);

    // R5 full read plus one byte beyond the registers
    startC();
    sendByte(8'hD3, 1'b0, a); expectItem("R1", 48'd1); observe({47'd0, a});
    recvByte(v, 1'b1); expectItem("R5", 48'd6); observe({40'd0, v});
    for (int k = 0; k < 6; k++) begin
      recvByte(v, 1'b1); expectItem("R5", {40'd0, model[k]}); observe({40'd0, v});
    end
    recvByte(v, 1'b0); expectItem("R5", 48'hFF); observe({40'd0, v});
    // R9 after the NACK the line stays released
    for (int i = 7; i >= 0; i--) begin logic b; bitIn(b); v[i] = b; end
    expectItem("R9", 48'hFF); observe({40'd0, v});
    stopC();

    // R9 NACK right after the length byte
    startC();
    sendByte(8'hD3, 1'b0, a); expectItem("R1", 48'd1); observe({47'd0, a});
    recvByte(v, 1'b0); expectItem("R5", 48'd6); observe({40'd0, v});
    for (int i = 7; i >= 0; i--) begin logic b; bitIn(b); v[i] = b; end
    expectItem("R9", 48'hFF); observe({40'd0, v});
    expectItem("R9", 48'd0); observe({47'd0, sdaOe});
    stopC();

    // R10 repeated start restarts at register 0, then a read after a restart
    startC();
    writeSeq('{8'h77}, "R10", 1'b0);
    startC();
    writeSeq('{8'h88}, "R10", 1'b0);
    startC();
    sendByte(8'hD3, 1'b0, a); expectItem("R10", 48'd1); observe({47'd0, a});
    recvByte(v, 1'b1); expectItem("R10", 48'd6); observe({40'd0, v});
    recvByte(v, 1'b0); expectItem("R10", 48'h88); observe({40'd0, v});
    stopC();
    expectItem("R10", modelVec()); observe(cfg);

    // R11 one-cycle pulses on both lines during data bits
    startC();
    writeSeq('{8'h3C, 8'hC3}, "R11", 1'b1);
    stopC();
    expectItem("R11", modelVec()); observe(cfg);

    // R7 drive changes never seen during a settled high SCL phase
    expectItem("R7", 48'd0); observe(48'(r7Bad));

    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL scoreboard leftover actual %0d expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end
endmodule